// File: doc/BRIEF.md
# Triggered Sample Capture Buffer

This block manages a single-port style sample store that serves three masters in turn. A host fills or inspects it through a narrow 16-bit register port. A streaming I/Q input can be recorded into it around a trigger strobe. Its whole contents can be streamed out to a wider downstream datapath. A two-bit status code shows which of these activities owns the store. A latched trigger address shows where the event landed in the circular buffer, so software can unwrap the record.

Each stored word is 32 bits: the I sample in bits 31:16 and the Q sample in bits 15:0. The host builds a word from two writes. The first stages the low half. The second carries the high half and commits the full word at the current address, optionally stepping the address. Depth is a parameter (a power of two). Playback support can be removed by parameter for a capture-only instance.

Top module: `trig_capture_buf`

## Requirements
- R1: The status code at host register 3, bits 13:12, reads 00 when idle, 01 when armed, 10 when loading and 11 when sending. Hardware reset leaves it at 00.
- R2: A host write to register 0 (staging) only holds the 16-bit value, which reads back at register 0. It writes nothing into the store.
- R3: A host write to register 1 stores {written value, staged value} at the current address.
- R4: Host register 2 holds the address in its low bits and the auto-step enable in bit 15. After a register 1 write the address advances by one, wrapping at the depth, only when that bit is 1. Otherwise it holds.
- R5: An arm pulse moves idle to armed. A trigger strobe while armed copies the current write address into register 3, bits [AW-1:0], and moves to loading.
- R6: While armed or loading, every cycle with input valid writes {I, Q} at the address and advances it circularly. The sample in the trigger cycle counts as the first post-trigger sample. Once depth minus the pretrigger count have been counted, the state returns to idle.
- R7: While the state is not idle, host writes to registers 0, 1 and 2 have no effect.
- R8: A play pulse in idle enters send. The block then presents every entry from address 0 upward, one per cycle with out_valid high, and returns to idle after the last read.
- R9: Each output sample is MSB-justified: out_i = {I, 4'b0000}, out_q = {Q, 4'b0000}.
- R10: With playback disabled by parameter, the play pulse is ignored and the status never reads 11.
- R11: A soft reset pulse returns the state to idle and clears the address, auto-step bit, staged word and trigger position.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| soft_rst | input | 1 | Synchronous clear of state and registers |
| host_we | input | 1 | Host register write strobe |
| host_sel | input | 2 | Host register select (0 stage, 1 commit, 2 address, 3 status) |
| host_wdata | input | 16 | Host write data |
| host_rdata | output | 16 | Host read data for the selected register |
| cfg_pretrig | input | AW | Samples kept before the trigger |
| arm | input | 1 | Start capture (from idle) |
| play | input | 1 | Start playback (from idle) |
| in_valid | input | 1 | Input sample valid |
| in_trig | input | 1 | Trigger strobe |
| in_i | input | 16 | Input I sample |
| in_q | input | 16 | Input Q sample |
| out_valid | output | 1 | Playback sample valid |
| out_i | output | 20 | Justified I output |
| out_q | output | 20 | Justified Q output |

## Verification
The bench builds a 16-entry instance with playback enabled. At that depth the address wraps during both host auto-stepping and capture. A trigger placed a few samples in overwrites the oldest pre-trigger entry, and a pretrigger count of depth minus one yields the one-sample capture. A second 8-entry instance with playback disabled receives the same stimulus, so the ignored play command is observed in the same cycles that the main instance enters send.

// File: rtl/cap_pkg.sv
package cap_pkg;

    localparam int HOST_W      = 16;
    localparam int AUTOINC_BIT = 15;
    localparam int STAT_LSB    = 12;

    localparam logic [1:0] SEL_LO   = 2'd0;
    localparam logic [1:0] SEL_HI   = 2'd1;
    localparam logic [1:0] SEL_ADDR = 2'd2;
    localparam logic [1:0] SEL_STAT = 2'd3;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'b00,
        ST_ARMED = 2'b01,
        ST_LOAD  = 2'b10,
        ST_SEND  = 2'b11
    } cap_state_e;

endpackage

// File: rtl/cap_ram.sv
module cap_ram #(
    parameter int DEPTH = 2048,
    parameter int W     = 32,
    localparam int AW   = $clog2(DEPTH)
) (
    input  logic          clk,
    input  logic          we,
    input  logic [AW-1:0] waddr,
    input  logic [W-1:0]  wdata,
    input  logic [AW-1:0] raddr,
    output logic [W-1:0]  rdata
);

    logic [W-1:0] mem [DEPTH];

    always_ff @(posedge clk) begin
        if (we) begin
            mem[waddr] <= wdata;
        end
        rdata <= mem[raddr];
    end

endmodule

// File: rtl/cap_fmt.sv
module cap_fmt #(
    parameter int IN_W  = 16,
    parameter int OUT_W = 20,
    parameter int LANES = 2,
    localparam int PAD  = OUT_W - IN_W
) (
    input  logic [LANES*IN_W-1:0]  in_word,
    output logic [LANES*OUT_W-1:0] out_bus
);

    for (genvar l = 0; l < LANES; l++) begin : g_lane
        if (PAD > 0) begin : g_pad
            assign out_bus[l*OUT_W +: OUT_W] = {in_word[l*IN_W +: IN_W], {PAD{1'b0}}};
        end else begin : g_nopad
            assign out_bus[l*OUT_W +: OUT_W] = in_word[l*IN_W +: OUT_W];
        end
    end

endmodule

// File: rtl/trig_capture_buf.sv
module trig_capture_buf
    import cap_pkg::*;
#(
    parameter int DEPTH        = 2048,
    parameter bit HAS_PLAYBACK = 1'b1,
    parameter int OUT_W        = 20,
    localparam int AW          = $clog2(DEPTH)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              soft_rst,
    input  logic              host_we,
    input  logic [1:0]        host_sel,
    input  logic [HOST_W-1:0] host_wdata,
    output logic [HOST_W-1:0] host_rdata,
    input  logic [AW-1:0]     cfg_pretrig,
    input  logic              arm,
    input  logic              play,
    input  logic              in_valid,
    input  logic              in_trig,
    input  logic [HOST_W-1:0] in_i,
    input  logic [HOST_W-1:0] in_q,
    output logic              out_valid,
    output logic [OUT_W-1:0]  out_i,
    output logic [OUT_W-1:0]  out_q
);

    localparam int          WORD_W  = 2 * HOST_W;
    localparam logic [AW:0] DEPTH_W = (AW+1)'(DEPTH);
    localparam logic [AW-1:0] LAST_A = AW'(DEPTH - 1);

    typedef struct packed {
        cap_state_e        st;
        logic [AW-1:0]     addr;
        logic              auto_inc;
        logic [HOST_W-1:0] lo;
        logic [AW-1:0]     tpos;
        logic [AW:0]       post;
        logic [AW-1:0]     rptr;
        logic              oval;
    } regs_t;

    regs_t q, d;

    logic              ram_we;
    logic [AW-1:0]     ram_waddr;
    logic [WORD_W-1:0] ram_wdata;
    logic [WORD_W-1:0] ram_rdata;
    logic [AW:0]       target;
    logic [AW:0]       post_inc;
    logic [AW:0]       post_first;
    logic [2*OUT_W-1:0] fmt_bus;

    // next-state computation
    always_comb begin
        d          = q;
        ram_we     = 1'b0;
        ram_waddr  = q.addr;
        ram_wdata  = '0;
        target     = DEPTH_W - {1'b0, cfg_pretrig};
        post_inc   = q.post + {{AW{1'b0}}, in_valid};
        post_first = {{AW{1'b0}}, in_valid};
        d.oval     = (q.st == ST_SEND);

        if (soft_rst) begin
            d = '0;
        end else begin
            unique case (q.st)
                ST_IDLE: begin
                    if (host_we) begin
                        case (host_sel)
                            SEL_LO: d.lo = host_wdata;
                            SEL_HI: begin
                                ram_we    = 1'b1;
                                ram_wdata = {host_wdata, q.lo};
                                if (q.auto_inc) begin
                                    d.addr = q.addr + 1'b1;
                                end
                            end
                            SEL_ADDR: begin
                                d.addr     = host_wdata[AW-1:0];
                                d.auto_inc = host_wdata[AUTOINC_BIT];
                            end
                            default: ;
                        endcase
                    end
                    if (arm) begin
                        d.st = ST_ARMED;
                    end else if (play && HAS_PLAYBACK) begin
                        d.st   = ST_SEND;
                        d.rptr = '0;
                    end
                end
                ST_ARMED: begin
                    if (in_valid) begin
                        ram_we    = 1'b1;
                        ram_wdata = {in_i, in_q};
                        d.addr    = q.addr + 1'b1;
                    end
                    if (in_trig) begin
                        d.tpos = q.addr;
                        d.post = post_first;
                        d.st   = (post_first == target) ? ST_IDLE : ST_LOAD;
                    end
                end
                ST_LOAD: begin
                    if (in_valid) begin
                        ram_we    = 1'b1;
                        ram_wdata = {in_i, in_q};
                        d.addr    = q.addr + 1'b1;
                        d.post    = post_inc;
                        if (post_inc == target) begin
                            d.st = ST_IDLE;
                        end
                    end
                end
                ST_SEND: begin
                    d.rptr = q.rptr + 1'b1;
                    if (q.rptr == LAST_A) begin
                        d.st = ST_IDLE;
                    end
                end
                default: d.st = ST_IDLE;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q <= '0;
        end else begin
            q <= d;
        end
    end

    // host read mux
    always_comb begin
        host_rdata = '0;
        case (host_sel)
            SEL_LO: host_rdata = q.lo;
            SEL_ADDR: begin
                host_rdata[AW-1:0]        = q.addr;
                host_rdata[AUTOINC_BIT]   = q.auto_inc;
            end
            SEL_STAT: begin
                host_rdata[STAT_LSB +: 2] = q.st;
                host_rdata[AW-1:0]        = q.tpos;
            end
            default: host_rdata = '0;
        endcase
    end

    cap_ram #(.DEPTH(DEPTH), .W(WORD_W)) u_ram (
        .clk   (clk),
        .we    (ram_we),
        .waddr (ram_waddr),
        .wdata (ram_wdata),
        .raddr (q.rptr),
        .rdata (ram_rdata)
    );

    cap_fmt #(.IN_W(HOST_W), .OUT_W(OUT_W), .LANES(2)) u_fmt (
        .in_word (ram_rdata),
        .out_bus (fmt_bus)
    );

    assign out_valid = q.oval;
    assign out_i     = fmt_bus[2*OUT_W-1:OUT_W];
    assign out_q     = fmt_bus[OUT_W-1:0];

    // checks
    p_stage_no_write_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (q.st == ST_IDLE && host_we && host_sel == SEL_LO && !soft_rst) |-> !ram_we);

    p_addr_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (q.st == ST_IDLE && host_we && host_sel == SEL_HI && !q.auto_inc && !soft_rst)
        |=> $stable(q.addr));

    p_trig_latch_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (q.st == ST_ARMED && in_trig && !soft_rst) |=> (q.tpos == $past(q.addr)));

    p_load_from_armed_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (q.st == ST_LOAD && $past(q.st) != ST_LOAD) |-> ($past(q.st) == ST_ARMED));

    p_host_ignored_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (q.st != ST_IDLE && !soft_rst) |=> ($stable(q.lo) && $stable(q.auto_inc)));

    p_valid_after_send_r8: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> ($past(q.st) == ST_SEND));

    p_send_ends_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (q.st == ST_SEND && q.rptr == LAST_A && !soft_rst) |=> (q.st == ST_IDLE));

    if (!HAS_PLAYBACK) begin : g_nosend_chk
        p_no_send_r10: assert property (@(posedge clk) disable iff (!rst_n)
            q.st != ST_SEND);
    end

endmodule

// File: tb/trig_capture_buf_bench.sv
module trig_capture_buf_bench;

    localparam int D  = 16;
    localparam int DS = 8;

    logic clk = 1'b0;
    always #5 clk = ~clk;

    logic        rst_n = 1'b0, soft_rst = 1'b0, host_we = 1'b0;
    logic [1:0]  host_sel = 2'd3;
    logic [15:0] host_wdata = '0;
    logic [3:0]  pretrig = '0;
    logic        arm = 1'b0, play = 1'b0, in_valid = 1'b0, in_trig = 1'b0;
    logic [15:0] in_i = '0, in_q = '0;

    logic [15:0] rdata, rdata_s;
    logic        ov, ov_s;
    logic [19:0] oi, oq, oi_s, oq_s;

    trig_capture_buf #(.DEPTH(D), .HAS_PLAYBACK(1'b1)) u_trig_capture_buf (
        .clk(clk), .rst_n(rst_n), .soft_rst(soft_rst), .host_we(host_we),
        .host_sel(host_sel), .host_wdata(host_wdata), .host_rdata(rdata),
        .cfg_pretrig(pretrig), .arm(arm), .play(play), .in_valid(in_valid),
        .in_trig(in_trig), .in_i(in_i), .in_q(in_q),
        .out_valid(ov), .out_i(oi), .out_q(oq)
    );

    trig_capture_buf #(.DEPTH(DS), .HAS_PLAYBACK(1'b0)) u_trig_capture_buf_small (
        .clk(clk), .rst_n(rst_n), .soft_rst(soft_rst), .host_we(host_we),
        .host_sel(host_sel), .host_wdata(host_wdata), .host_rdata(rdata_s),
        .cfg_pretrig(pretrig[2:0]), .arm(arm), .play(play), .in_valid(in_valid),
        .in_trig(in_trig), .in_i(in_i), .in_q(in_q),
        .out_valid(ov_s), .out_i(oi_s), .out_q(oq_s)
    );

    // ---------------- reference model ----------------
    int          m_st = 0, m_addr = 0, m_tpos = 0, m_left = 0;
    bit          m_auto = 1'b0, m_oval = 1'b0;
    logic [15:0] m_lo = '0;
    logic [31:0] m_mem [D];
    logic [31:0] m_word = '0;
    logic [31:0] play_q [$];

    always @(posedge clk) begin
        if (!rst_n) begin
            m_st = 0; m_addr = 0; m_tpos = 0; m_auto = 0; m_lo = '0; m_oval = 0;
            play_q.delete();
        end else begin
            m_oval = (m_st == 3);
            if (m_oval) m_word = play_q.pop_front();
            if (soft_rst) begin
                m_st = 0; m_addr = 0; m_tpos = 0; m_auto = 0; m_lo = '0; m_oval = 0;
                play_q.delete();
            end else begin
                case (m_st)
                    0: begin
                        if (host_we) begin
                            if (host_sel == 2'd0) m_lo = host_wdata;
                            else if (host_sel == 2'd1) begin
                                m_mem[m_addr] = {host_wdata, m_lo};
                                if (m_auto) m_addr = (m_addr + 1) % D;
                            end else if (host_sel == 2'd2) begin
                                m_addr = int'(host_wdata[3:0]);
                                m_auto = host_wdata[15];
                            end
                        end
                        if (arm) m_st = 1;
                        else if (play) begin
                            m_st = 3;
                            for (int i = 0; i < D; i++) play_q.push_back(m_mem[i]);
                        end
                    end
                    1: begin
                        if (in_trig) m_tpos = m_addr;
                        if (in_valid) begin
                            m_mem[m_addr] = {in_i, in_q};
                            m_addr = (m_addr + 1) % D;
                        end
                        if (in_trig) begin
                            m_left = D - int'(pretrig) - (in_valid ? 1 : 0);
                            m_st = (m_left == 0) ? 0 : 2;
                        end
                    end
                    2: begin
                        if (in_valid) begin
                            m_mem[m_addr] = {in_i, in_q};
                            m_addr = (m_addr + 1) % D;
                            m_left--;
                            if (m_left == 0) m_st = 0;
                        end
                    end
                    default: begin
                        if (play_q.size() == 0) m_st = 0;
                    end
                endcase
            end
        end
    end

    // ---------------- per-clock comparison ----------------
    int          mon_checks = 0, mon_errors = 0, got_n = 0;
    bit          done = 1'b0;
    logic [19:0] got_i [64];
    logic [19:0] got_q [64];

    task automatic mchk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        mon_checks++;
        if (act !== exp) begin
            mon_errors++;
            $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
        end
    endtask

    always @(posedge clk) begin
        #2;
        if (rst_n && !done) begin
            if (host_sel == 2'd3 && !host_we) begin
                mchk("R1 status code", 32'(rdata[13:12]), 32'(m_st));
                mchk("R5 trigger position", 32'(rdata[3:0]), 32'(m_tpos));
                mchk("R10 small never sends", 32'(rdata_s[13:12] == 2'b11), 32'd0);
            end
            mchk("R8 out_valid", 32'(ov), 32'(m_oval));
            mchk("R10 small out_valid", 32'(ov_s), 32'd0);
            if (ov && m_oval) begin
                mchk("R9 out_i justified", 32'(oi), 32'({m_word[31:16], 4'h0}));
                mchk("R9 out_q justified", 32'(oq), 32'({m_word[15:0], 4'h0}));
                if (got_n < 64) begin
                    got_i[got_n] = oi;
                    got_q[got_n] = oq;
                end
                got_n++;
            end
        end
    end

    // ---------------- directed sequence ----------------
    int checks = 0, errors = 0;
    bit timed_out = 1'b0;

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic hwr(input logic [1:0] s, input logic [15:0] v);
        @(negedge clk);
        host_we = 1'b1; host_sel = s; host_wdata = v;
        @(negedge clk);
        host_we = 1'b0; host_sel = 2'd3;
    endtask

    task automatic hrd(input logic [1:0] s, output logic [15:0] v);
        @(negedge clk);
        host_sel = s;
        #1 v = rdata;
        host_sel = 2'd3;
    endtask

    task automatic pulse_arm();
        @(negedge clk); arm = 1'b1;
        @(negedge clk); arm = 1'b0;
    endtask

    task automatic wait_idle();
        for (int n = 0; n < 100; n++) begin
            @(negedge clk);
            #1;
            if (rdata[13:12] == 2'b00) break;
        end
        repeat (2) @(negedge clk);
    endtask

    task automatic run_all();
        logic [15:0] v;
        int base;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        hrd(2'd3, v); chk("R1 reset status idle", 32'(v), 32'h0);
        hrd(2'd2, v); chk("R1 reset address", 32'(v), 32'h0);

        // R4: auto-step fill with wrap
        hwr(2'd2, 16'h8000);
        for (int k = 0; k < D; k++) begin
            hwr(2'd0, 16'h1000 + 16'(k));
            hwr(2'd1, 16'h2000 + 16'(k));
        end
        hrd(2'd2, v); chk("R4 auto-step wraps to 0", 32'(v), 32'h8000);

        // R2 / R3 / R4 hold
        hwr(2'd2, 16'h0005);
        hwr(2'd0, 16'hBEEF);
        hrd(2'd0, v); chk("R2 staged readback", 32'(v), 32'hBEEF);
        hwr(2'd1, 16'h7777);
        hrd(2'd2, v); chk("R4 address holds", 32'(v), 32'h0005);
        hwr(2'd2, 16'h0006);
        hwr(2'd0, 16'hDEAD);

        // R8 playback
        base = got_n;
        @(negedge clk); play = 1'b1;
        @(negedge clk); play = 1'b0;
        #1;
        chk("R1 send status", 32'(rdata[13:12]), 32'h3);
        chk("R10 small ignores play", 32'(rdata_s[13:12]), 32'h0);
        wait_idle();
        chk("R8 entry count", 32'(got_n - base), 32'(D));
        chk("R8 first entry", 32'(got_i[base]), 32'({16'h2000, 4'h0}));
        chk("R8 last entry", 32'(got_i[base+15]), 32'({16'h200F, 4'h0}));
        chk("R3 commit high", 32'(got_i[base+5]), 32'({16'h7777, 4'h0}));
        chk("R3 commit low", 32'(got_q[base+5]), 32'({16'hBEEF, 4'h0}));
        chk("R2 stage did not write", 32'(got_q[base+6]), 32'({16'h1006, 4'h0}));
        chk("R9 low nibble zero", 32'(got_q[base+3][3:0]), 32'h0);

        // R7 host ignored while armed
        hwr(2'd2, 16'h0002);
        pulse_arm();
        #1 chk("R5 armed status", 32'(rdata[13:12]), 32'h1);
        hwr(2'd2, 16'h0009);
        hwr(2'd0, 16'h5555);
        hrd(2'd2, v); chk("R7 address write ignored", 32'(v), 32'h0002);
        hrd(2'd0, v); chk("R7 stage write ignored", 32'(v), 32'hDEAD);

        // R5 / R6 capture with gaps
        pretrig = 4'd4;
        for (int s = 0; s < 40; s++) begin
            @(negedge clk);
            in_valid = (s % 3 != 2);
            in_i = 16'h3000 + 16'(s);
            in_q = 16'h4000 + 16'(s);
            in_trig = (s == 7);
            if (s == 8) begin
                #1 chk("R5 loading after trigger", 32'(rdata[13:12]), 32'h2);
            end
        end
        @(negedge clk); in_valid = 1'b0; in_trig = 1'b0;
        hrd(2'd3, v); chk("R5 trigger address", 32'(v), 32'h0007);
        hrd(2'd2, v); chk("R6 final address", 32'(v), 32'h0003);

        base = got_n;
        @(negedge clk); play = 1'b1;
        @(negedge clk); play = 1'b0;
        wait_idle();
        chk("R6 trigger sample", 32'(got_i[base+7]), 32'({16'h3007, 4'h0}));
        chk("R6 wrap overwrote oldest", 32'(got_i[base+2]), 32'({16'h3018, 4'h0}));
        chk("R6 oldest kept", 32'(got_q[base+3]), 32'({16'h4001, 4'h0}));

        // R6 one-sample capture
        pretrig = 4'd15;
        pulse_arm();
        @(negedge clk); in_valid = 1'b1; in_trig = 1'b1; in_i = 16'h5000; in_q = 16'h6000;
        @(negedge clk); in_valid = 1'b0; in_trig = 1'b0;
        #1 chk("R6 single sample ends capture", 32'(rdata[13:12]), 32'h0);
        hrd(2'd2, v); chk("R6 single sample address", 32'(v), 32'h0004);
        hrd(2'd3, v); chk("R5 trigger at wrap point", 32'(v), 32'h0003);

        // R11 soft reset mid-capture
        pretrig = 4'd0;
        hwr(2'd0, 16'h1234);
        pulse_arm();
        @(negedge clk); in_trig = 1'b1; in_valid = 1'b0;
        @(negedge clk); in_trig = 1'b0; in_valid = 1'b1;
        repeat (3) @(negedge clk);
        in_valid = 1'b0;
        #1 chk("R1 loading status", 32'(rdata[13:12]), 32'h2);
        @(negedge clk); soft_rst = 1'b1;
        @(negedge clk); soft_rst = 1'b0;
        #1 chk("R11 status cleared", 32'(rdata[13:12]), 32'h0);
        hrd(2'd2, v); chk("R11 address cleared", 32'(v), 32'h0);
        hrd(2'd0, v); chk("R11 stage cleared", 32'(v), 32'h0);
        hrd(2'd3, v); chk("R11 trigger position cleared", 32'(v), 32'h0);
        repeat (4) @(negedge clk);
    endtask

    initial begin
        fork
            run_all();
            begin
                repeat (20000) @(posedge clk);
                timed_out = 1'b1;
            end
        join_any
        disable fork;
        if (timed_out) begin
            checks++;
            errors++;
            $display("FAIL watchdog: actual=timeout expected=completion");
        end
        done = 1'b1;
        #1;
        $display("Result: errors=%0d of %0d checks", errors + mon_errors, checks + mon_checks);
        $finish;
    end

endmodule